// File: doc/BRIEF.md
# Byte ALU with Condition Flags

This block is the combinational arithmetic and logic unit of a small accumulator-style processor core. From a 4-bit operation code, an accumulator operand, a second operand and the current condition-flag byte, it returns the new accumulator value and a new flag byte within the same cycle. The surrounding core decodes instructions, fetches operands and registers both outputs. The block has no state of its own.

Each operation rewrites only its own set of flags. The other flag bits are copied from the incoming byte. The parity/overflow bit has two meanings. Logic operations write result parity into it, and arithmetic operations write signed overflow into it. The subtract flag records whether the operation was a subtraction.

Two elaboration options select the carry-chain style and the parity-network style. The operand width and the position of the half-carry tap are parameters. The flag byte is always 8 bits wide.

Top module: `byte_alu`

## Requirements
- R1: Operation codes: 0 ADD, 1 ADC, 2 SUB, 3 SBC, 4 CP, 5 AND, 6 OR, 7 XOR, 8 INC, 9 DEC, 10 NEG, 11 CPL, 12 SCF, 13 CCF. Flag bit positions: sign S=7, zero Z=6, half-carry H=4, parity/overflow PV=2, subtract N=1, carry C=0.
- R2: ADD returns a+b and ADC returns a+b+C. C is the carry out of bit 7, H is the carry out of bit 3, PV is signed two's-complement overflow, and N=0.
- R3: SUB returns a-b and SBC returns a-b-C. C is the borrow out of bit 7, H is the borrow out of bit 3, PV is signed overflow, and N=1.
- R4: CP sets every flag exactly as SUB would, but result_o equals a unchanged.
- R5: For every operation that writes S and Z, S is bit 7 of the computed value and Z is 1 when that value is zero. For CP, the computed value is the difference.
- R6: AND returns a&b and sets C=0, N=0, H=1. PV is 1 when the result has an even number of set bits.
- R7: OR returns a|b and XOR returns a^b. Both set C=0, N=0, H=0, and PV to the even parity of the result.
- R8: INC returns a+1 and DEC returns a-1. Both write S, Z, H and PV (overflow). N is 0 for INC and 1 for DEC. C keeps its incoming value.
- R9: NEG returns 0-a and sets C, H and PV as the subtraction 0-a would, with N=1.
- R10: CPL returns ~a and sets H=1 and N=1. S, Z, PV and C are left unchanged.
- R11: SCF and CCF return a. SCF sets C=1, N=0, H=0. CCF inverts C and sets N=0, leaving H unchanged. Both leave S, Z and PV unchanged.
- R12: Flag bits 5 and 3 are always copied from the input. Codes 14 and 15 return a with the whole flag byte unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_i | input | 4 | Operation code (R1) |
| a_i | input | WIDTH (8) | Accumulator operand |
| b_i | input | WIDTH (8) | Second operand for two-operand operations |
| flags_i | input | 8 | Incoming flag byte |
| result_o | output | WIDTH (8) | New accumulator value |
| flags_o | output | 8 | New flag byte |

## Verification
The hardest cases to reach are the corners where the half-carry, the carry and the signed overflow disagree. One example is 0x7F+0x01, which sets H and PV but leaves C clear. Another is a borrow-in that turns 0x80-0x00 into an overflow. Only particular operand pairs combined with a particular incoming carry produce them. The bench sweeps every accumulator value against a strided second operand, with 0x7F, 0x80 and 0xFF added to the stride. It runs ADC and SBC once with the incoming carry forced low and once forced high. The incoming flag byte varies from vector to vector, so the pass-through bits and the flags each operation must keep are exposed to corruption on every check.

// File: rtl/byte_alu_pkg.sv
package byte_alu_pkg;

   // Operation codes (R1)
   typedef enum logic [3:0] {
      OP_ADD = 4'd0,
      OP_ADC = 4'd1,
      OP_SUB = 4'd2,
      OP_SBC = 4'd3,
      OP_CP  = 4'd4,
      OP_AND = 4'd5,
      OP_OR  = 4'd6,
      OP_XOR = 4'd7,
      OP_INC = 4'd8,
      OP_DEC = 4'd9,
      OP_NEG = 4'd10,
      OP_CPL = 4'd11,
      OP_SCF = 4'd12,
      OP_CCF = 4'd13
   } alu_op_e;

   // Flag byte, MSB first: S Z x5 H x3 PV N C (R1)
   typedef struct packed {
      logic s;
      logic z;
      logic x5;
      logic h;
      logic x3;
      logic pv;
      logic n;
      logic c;
   } alu_flags_t;

   // Logic unit selector
   typedef enum logic [1:0] {
      LG_AND = 2'd0,
      LG_OR  = 2'd1,
      LG_XOR = 2'd2,
      LG_NOT = 2'd3
   } logic_sel_e;

endpackage

// File: rtl/byte_alu_addsub.sv
module byte_alu_addsub #(
   parameter int WIDTH       = 8,
   parameter int NIBBLE      = 4,
   parameter int CARRY_STYLE = 0
) (
   input  logic [WIDTH-1:0] x_i,
   input  logic [WIDTH-1:0] y_i,
   input  logic             cin_i,
   input  logic             sub_i,
   output logic [WIDTH-1:0] res_o,
   output logic             carry_o,
   output logic             half_o,
   output logic             ovf_o
);
   localparam int MSB = WIDTH - 1;

   generate
      if (NIBBLE < 1 || NIBBLE >= WIDTH) begin : g_bad_nibble
         $error("byte_alu_addsub: NIBBLE must lie in 1..WIDTH-1");
      end
      if (CARRY_STYLE != 0 && CARRY_STYLE != 1) begin : g_bad_style
         $error("byte_alu_addsub: CARRY_STYLE must be 0 or 1");
      end

      if (CARRY_STYLE == 0) begin : g_wide
         // Whole-word add/subtract; borrow appears as the extra top bit
         logic [WIDTH:0]  wide;
         logic [NIBBLE:0] low;
         always_comb begin
            if (sub_i) begin
               wide = {1'b0, x_i} - {1'b0, y_i} - {{WIDTH{1'b0}}, cin_i};
               low  = {1'b0, x_i[NIBBLE-1:0]} - {1'b0, y_i[NIBBLE-1:0]}
                      - {{NIBBLE{1'b0}}, cin_i};
            end else begin
               wide = {1'b0, x_i} + {1'b0, y_i} + {{WIDTH{1'b0}}, cin_i};
               low  = {1'b0, x_i[NIBBLE-1:0]} + {1'b0, y_i[NIBBLE-1:0]}
                      + {{NIBBLE{1'b0}}, cin_i};
            end
         end
         assign res_o   = wide[WIDTH-1:0];
         assign carry_o = wide[WIDTH];
         assign half_o  = low[NIBBLE];
      end else begin : g_ripple
         // Bit-serial chain; subtraction as x + ~y + ~cin, borrow = ~carry
         logic [WIDTH:0]   c;
         logic [WIDTH-1:0] yy;
         assign yy   = sub_i ? ~y_i : y_i;
         assign c[0] = sub_i ? ~cin_i : cin_i;
         for (genvar i = 0; i < WIDTH; i++) begin : g_bit
            assign res_o[i] = x_i[i] ^ yy[i] ^ c[i];
            assign c[i+1]   = (x_i[i] & yy[i]) | (x_i[i] & c[i]) | (yy[i] & c[i]);
         end
         assign carry_o = c[WIDTH] ^ sub_i;
         assign half_o  = c[NIBBLE] ^ sub_i;
      end
   endgenerate

   // Signed overflow: operand signs compared against result sign
   always_comb begin
      if (sub_i)
         ovf_o = (x_i[MSB] != y_i[MSB]) && (res_o[MSB] != x_i[MSB]);
      else
         ovf_o = (x_i[MSB] == y_i[MSB]) && (res_o[MSB] != x_i[MSB]);
   end

   // A carry out of an addition means the sum wrapped below the first operand
   always_comb begin
      if (!sub_i && carry_o)
         p_add_wrap_r2: assert ((res_o < x_i) || (cin_i && res_o == x_i))
            else $error("add carry without wrap");
      if (sub_i && carry_o)
         p_sub_wrap_r3: assert ((res_o > x_i) || (cin_i && res_o == x_i))
            else $error("borrow without wrap");
   end

endmodule

// File: rtl/byte_alu_logic.sv
module byte_alu_logic
   import byte_alu_pkg::*;
#(
   parameter int WIDTH = 8
) (
   input  logic [WIDTH-1:0] a_i,
   input  logic [WIDTH-1:0] b_i,
   input  logic_sel_e       sel_i,
   output logic [WIDTH-1:0] res_o
);
   always_comb begin
      unique case (sel_i)
         LG_AND:  res_o = a_i & b_i;
         LG_OR:   res_o = a_i | b_i;
         LG_XOR:  res_o = a_i ^ b_i;
         default: res_o = ~a_i;
      endcase
   end

   always_comb begin
      if (sel_i == LG_AND)
         p_and_subset_r6: assert (((res_o & ~a_i) == '0) && ((res_o & ~b_i) == '0))
            else $error("and result outside operands");
      if (sel_i == LG_OR)
         p_or_cover_r7: assert (((res_o & a_i) == a_i) && ((res_o & b_i) == b_i))
            else $error("or result misses operand bits");
   end

endmodule

// File: rtl/byte_alu_parity.sv
module byte_alu_parity #(
   parameter int WIDTH = 8,
   parameter int CHAIN = 0
) (
   input  logic [WIDTH-1:0] data_i,
   output logic             even_o
);
   generate
      if (CHAIN == 0) begin : g_reduce
         assign even_o = ~(^data_i);
      end else begin : g_chain
         logic [WIDTH:0] acc;
         assign acc[0] = 1'b1;
         for (genvar i = 0; i < WIDTH; i++) begin : g_step
            assign acc[i+1] = acc[i] ^ data_i[i];
         end
         assign even_o = acc[WIDTH];
      end
   endgenerate

endmodule

// File: rtl/byte_alu.sv
module byte_alu
   import byte_alu_pkg::*;
#(
   parameter int WIDTH        = 8,
   parameter int NIBBLE       = 4,
   parameter int CARRY_STYLE  = 0,
   parameter int PARITY_CHAIN = 0
) (
   input  logic [3:0]       op_i,
   input  logic [WIDTH-1:0] a_i,
   input  logic [WIDTH-1:0] b_i,
   input  logic [7:0]       flags_i,
   output logic [WIDTH-1:0] result_o,
   output logic [7:0]       flags_o
);
   localparam int MSB = WIDTH - 1;
   localparam logic [WIDTH-1:0] ONE = {{(WIDTH-1){1'b0}}, 1'b1};

   generate
      if (WIDTH < 2) begin : g_bad_width
         $error("byte_alu: WIDTH must be at least 2");
      end
   endgenerate

   alu_op_e    op;
   alu_flags_t fin;
   alu_flags_t fo;

   assign op  = alu_op_e'(op_i);
   assign fin = alu_flags_t'(flags_i);

   // Operand steering for the adder
   logic [WIDTH-1:0] ax, ay;
   logic             acin, asub;

   always_comb begin
      ax   = a_i;
      ay   = b_i;
      acin = 1'b0;
      asub = 1'b0;
      case (op)
         OP_ADC: acin = fin.c;
         OP_SUB, OP_CP: asub = 1'b1;
         OP_SBC: begin asub = 1'b1; acin = fin.c; end
         OP_INC: ay = ONE;
         OP_DEC: begin ay = ONE; asub = 1'b1; end
         OP_NEG: begin ax = '0; ay = a_i; asub = 1'b1; end
         default: ;
      endcase
   end

   logic [WIDTH-1:0] core_res;
   logic             core_c, core_h, core_v;

   byte_alu_addsub #(
      .WIDTH      (WIDTH),
      .NIBBLE     (NIBBLE),
      .CARRY_STYLE(CARRY_STYLE)
   ) u_addsub (
      .x_i    (ax),
      .y_i    (ay),
      .cin_i  (acin),
      .sub_i  (asub),
      .res_o  (core_res),
      .carry_o(core_c),
      .half_o (core_h),
      .ovf_o  (core_v)
   );

   // Logic unit
   logic_sel_e       lsel;
   logic [WIDTH-1:0] lres;
   logic             lpar;

   always_comb begin
      case (op)
         OP_AND:  lsel = LG_AND;
         OP_OR:   lsel = LG_OR;
         OP_XOR:  lsel = LG_XOR;
         default: lsel = LG_NOT;
      endcase
   end

   byte_alu_logic #(.WIDTH(WIDTH)) u_logic (
      .a_i  (a_i),
      .b_i  (b_i),
      .sel_i(lsel),
      .res_o(lres)
   );

   byte_alu_parity #(.WIDTH(WIDTH), .CHAIN(PARITY_CHAIN)) u_parity (
      .data_i(lres),
      .even_o(lpar)
   );

   // Result and flag assembly
   always_comb begin
      fo       = fin;
      result_o = a_i;
      case (op)
         OP_ADD, OP_ADC, OP_SUB, OP_SBC, OP_CP, OP_NEG, OP_INC, OP_DEC: begin
            if (op != OP_CP) result_o = core_res;
            fo.s  = core_res[MSB];
            fo.z  = (core_res == '0);
            fo.h  = core_h;
            fo.pv = core_v;
            fo.n  = asub;
            if (op != OP_INC && op != OP_DEC) fo.c = core_c;
         end
         OP_AND, OP_OR, OP_XOR: begin
            result_o = lres;
            fo.s  = lres[MSB];
            fo.z  = (lres == '0);
            fo.h  = (op == OP_AND);
            fo.pv = lpar;
            fo.n  = 1'b0;
            fo.c  = 1'b0;
         end
         OP_CPL: begin
            result_o = lres;
            fo.h = 1'b1;
            fo.n = 1'b1;
         end
         OP_SCF: begin
            fo.c = 1'b1;
            fo.n = 1'b0;
            fo.h = 1'b0;
         end
         OP_CCF: begin
            fo.c = ~fin.c;
            fo.n = 1'b0;
         end
         default: ;
      endcase
   end

   assign flags_o = fo;

   // Checks at the block boundary
   always_comb begin
      p_undoc_bits_r12: assert (flags_o[5] == flags_i[5] && flags_o[3] == flags_i[3])
         else $error("pass-through bits changed");
      if (op_i == 4'd4)
         p_cp_keeps_a_r4: assert (result_o == a_i)
            else $error("compare altered accumulator");
      if (op_i == 4'd8 || op_i == 4'd9)
         p_step_keeps_c_r8: assert (flags_o[0] == flags_i[0])
            else $error("inc/dec touched carry");
      if (op_i <= 4'd3 || (op_i >= 4'd5 && op_i <= 4'd10))
         p_zero_sign_r5: assert (flags_o[6] == (result_o == '0) && flags_o[7] == result_o[MSB])
            else $error("zero/sign disagree with result");
      if (op_i >= 4'd11)
         p_keep_szp_r10: assert (flags_o[7] == flags_i[7] && flags_o[6] == flags_i[6]
                                 && flags_o[2] == flags_i[2])
            else $error("S/Z/PV changed by flag-only op");
   end

endmodule

// File: tb/byte_alu_bench.sv
`timescale 1ns/1ps
module byte_alu_bench;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic [3:0] op;
   logic [7:0] a, b, fin;
   logic [7:0] res;
   logic [7:0] fout;

   int checks = 0;
   int fails  = 0;
   bit done   = 0;

   always #2.5 clk = ~clk;

   byte_alu u_byte_alu (
      .op_i    (op),
      .a_i     (a),
      .b_i     (b),
      .flags_i (fin),
      .result_o(res),
      .flags_o (fout)
   );

   function automatic int sgn(input int v);
      return (v > 127) ? v - 256 : v;
   endfunction

   function automatic bit even_par(input int v);
      int cnt = 0;
      for (int i = 0; i < 8; i++) cnt += (v >> i) & 1;
      return (cnt % 2) == 0;
   endfunction

   function automatic string tag_of(input int o);
      case (o)
         0, 1:    return "R2";
         2, 3:    return "R3";
         4:       return "R4";
         5:       return "R6";
         6, 7:    return "R7";
         8, 9:    return "R8";
         10:      return "R9";
         11:      return "R10";
         12, 13:  return "R11";
         default: return "R12";
      endcase
   endfunction

   // Expected result and flags, computed arithmetically (R1 layout)
   task automatic model(input int o, input int av, input int bv, input int fv,
                        output int er, output int ef);
      int x, y, ci, t, h, sv, r;
      bit sub, c, v, hh;
      int cf = fv & 1;
      er = av;
      ef = fv;
      if (o <= 4 || (o >= 8 && o <= 10)) begin
         x = av; y = bv; ci = 0; sub = 0;
         case (o)
            1: ci = cf;
            2, 4: sub = 1;
            3: begin sub = 1; ci = cf; end
            8: y = 1;
            9: begin y = 1; sub = 1; end
            10: begin x = 0; y = av; sub = 1; end
            default: ;
         endcase
         if (sub) begin
            t  = x - y - ci;
            c  = t < 0;
            h  = (x % 16) - (y % 16) - ci;
            hh = h < 0;
            sv = sgn(x) - sgn(y) - ci;
         end else begin
            t  = x + y + ci;
            c  = t > 255;
            h  = (x % 16) + (y % 16) + ci;
            hh = h > 15;
            sv = sgn(x) + sgn(y) + ci;
         end
         r = (t + 512) % 256;
         v = (sv > 127) || (sv < -128);
         if (o == 8 || o == 9) c = cf[0];
         ef = (fv & 8'h28) | (((r >> 7) & 1) << 7) | ((r == 0) << 6) | (hh << 4)
              | (v << 2) | (sub << 1) | c;
         er = (o == 4) ? av : r;
      end else if (o >= 5 && o <= 7) begin
         r  = (o == 5) ? (av & bv) : (o == 6) ? (av | bv) : (av ^ bv);
         ef = (fv & 8'h28) | (((r >> 7) & 1) << 7) | ((r == 0) << 6)
              | ((o == 5) << 4) | (even_par(r) << 2);
         er = r;
      end else if (o == 11) begin
         er = (~av) & 255;
         ef = fv | 8'h12;
      end else if (o == 12) begin
         ef = (fv & ~8'h12) | 1;
      end else if (o == 13) begin
         ef = (fv & ~8'h02) ^ 1;
      end
   endtask

   task automatic apply(input int o, input int av, input int bv, input int fv);
      int er, ef;
      @(posedge clk);
      op  <= o[3:0];
      a   <= av[7:0];
      b   <= bv[7:0];
      fin <= fv[7:0];
      @(negedge clk);
      model(o, av, bv, fv, er, ef);
      checks++;
      if (res !== er[7:0] || fout !== ef[7:0]) begin
         fails++;
         $display("FAIL %s (R1 R5 R12) op=%0d a=%02h b=%02h f=%02h: result %02h exp %02h, flags %02h exp %02h",
                  tag_of(o), o, av, bv, fv, res, er[7:0], fout, ef[7:0]);
      end
   endtask

   function automatic int bsel(input int i);
      if (i < 43) return i * 6;
      if (i == 43) return 127;
      if (i == 44) return 128;
      return 255;
   endfunction

   initial begin
      op = 4'd0; a = 8'h00; b = 8'h00; fin = 8'h00;
      repeat (3) @(posedge clk);
      rst = 1'b0;
      // Quiet start: ADD 0+0 with clear flags gives zero and Z only (R5)
      @(negedge clk);
      checks++;
      if (res !== 8'h00 || fout !== 8'h40) begin
         fails++;
         $display("FAIL R5 idle: result %02h exp 00, flags %02h exp 40", res, fout);
      end
      // Two-operand sweeps (R2 R3 R4 R6 R7); ADC/SBC with carry in 0 and 1
      for (int o = 0; o <= 7; o++) begin
         for (int pass = 0; pass < ((o == 1 || o == 3) ? 2 : 1); pass++) begin
            for (int av = 0; av < 256; av++) begin
               for (int bi = 0; bi < 46; bi++) begin
                  int bv = bsel(bi);
                  int fv = (av * 7 + bv * 13 + o) & 8'hFE;
                  if (o == 1 || o == 3) fv = fv | pass;
                  else fv = fv | ((av ^ bv) & 1);
                  apply(o, av, bv, fv);
               end
            end
         end
      end
      // One-operand and flag-only ops (R8 R9 R10 R11), unused codes (R12)
      for (int o = 8; o <= 15; o++) begin
         for (int av = 0; av < 256; av++) begin
            for (int k = 0; k < 4; k++) begin
               int fv = ((av * 29 + k * 85 + o) & 8'hFF);
               apply(o, av, (av * 3) & 255, fv);
            end
         end
      end
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog: run did not complete, actual running exp done");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

endmodule